// File: doc/BRIEF.md
# Masked Change-Detection Capture Unit

The unit watches a 32-bit parallel input port and records a snapshot of it whenever a line it monitors changes state. The port is first brought into the local clock domain through a flop chain. Each new synchronised sample is then compared with the sample taken one cycle earlier. When a difference shows up on any bit whose mask bit is set, the complete synchronised word is stored and offered on a valid/ready output. The stored word includes the bits that are not monitored.

The output holds one word. The producer side cannot be stalled, so back-pressure cannot slow the port. A hit that arrives while an earlier word is still waiting (`cap_valid` high, `cap_ready` low) is dropped, and a sticky `overflow` flag records the loss. A word that is accepted in the same cycle as a new hit is replaced by the new word with no loss. Software loads the mask only while the unit is disabled.

Raising `enable` arms the unit. The first enabled sample only sets up the comparison reference, and arming also clears `overflow`.

Top module: `chg_capture`

## Requirements
- R1: After reset, `cap_valid` and `overflow` are low and the mask is all ones, so every line is monitored.
- R2: A change on a monitored line produces one stored word equal to the full port value, unmonitored bits included. For an input change applied before a rising edge, `cap_valid` rises after the third rising edge.
- R3: A sample in which only unmonitored lines changed produces no stored word.
- R4: The first enabled cycle after a disabled period only loads the reference. No word is produced, even if the port changed while the unit was disabled.
- R5: While `enable` is low, no word enters the output.
- R6: While `cap_valid` is high and `cap_ready` is low, `cap_valid` and `cap_data` hold. A cycle with both high removes the word.
- R7: A hit while an unaccepted word is held sets `overflow`. The new word is dropped and the held word is kept.
- R8: `overflow` stays set, including while disabled, until the unit is armed again.
- R9: A mask write (`mask_wr` high) while `enable` is high is ignored.
- R10: A mask write while `enable` is low loads `mask_data`. Mask bit i set means port line i is monitored.
- R11: When the held word is accepted in the same cycle as a new hit, the new word takes its place and `overflow` stays low. Changes in consecutive cycles each yield a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Unit armed and capturing while high |
| mask_wr | input | 1 | Mask load strobe, honoured only while disabled |
| mask_data | input | 32 | New mask value, bit set = line monitored |
| port_in | input | 32 | Asynchronous parallel input port |
| cap_valid | output | 1 | A captured word is offered |
| cap_ready | input | 1 | Consumer accepts the offered word |
| cap_data | output | 32 | Captured full port word |
| overflow | output | 1 | Sticky: a capture was lost to a full output |

## Verification
The first pattern toggles single monitored bits with a known mask. It pins down the exact latency and shows that the stored word carries unmonitored bits. The second toggles unmonitored-only bits, and the third writes the mask while enabled; both separate a correct mask from one that is ignored or loaded at the wrong time. Back-to-back changes with `cap_ready` held high separate a same-cycle replace from a false overflow. Changes with `cap_ready` low expose dropping, holding and stickiness. A long pseudo-random walk mixes monitored and unmonitored toggles, and its captured sequence is compared word by word against a model built from the applied values.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic {
    ST_OFF,
    ST_LIVE
  } det_state_t;

  localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/chg_mask_reg.sv
module chg_mask_reg #(
  parameter int         W         = 32,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  // Loads are accepted only while the unit is disabled.
  always_ff @(posedge clk) begin
    if (!rst_n)              mask <= RESET_VAL;
    else if (wr && !enable)  mask <= wdata;
  end
endmodule

// File: rtl/chg_detect.sv
module chg_detect
  import chg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] samp,
  output logic         hit,
  output logic         arm,
  output logic [W-1:0] word
);
  det_state_t   state_q;
  logic [W-1:0] ref_q;
  logic [W-1:0] diff;

  always_comb begin
    diff = (samp ^ ref_q) & mask;
    arm  = enable && (state_q == ST_OFF);
    hit  = enable && (state_q == ST_LIVE) && (|diff);
    word = samp;
  end

  // The reference follows every sample, so unmonitored changes never
  // accumulate into a later false hit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      ref_q   <= '0;
    end else if (!enable) begin
      state_q <= ST_OFF;
    end else begin
      state_q <= ST_LIVE;
      ref_q   <= samp;
    end
  end
endmodule

// File: rtl/chg_out_stage.sv
module chg_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         arm,
  input  logic [W-1:0] word,
  input  logic         cap_ready,
  output logic         cap_valid,
  output logic [W-1:0] cap_data,
  output logic         overflow
);
  logic take;
  logic room;

  always_comb begin
    take = cap_valid && cap_ready;
    room = !cap_valid || take;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_data  <= '0;
    end else if (hit && room) begin
      cap_valid <= 1'b1;
      cap_data  <= word;
    end else if (take) begin
      cap_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              overflow <= 1'b0;
    else if (arm)            overflow <= 1'b0;
    else if (hit && !room)   overflow <= 1'b1;
  end
endmodule

// File: rtl/chg_capture.sv
module chg_capture
  import chg_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = MIN_SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_data,
  input  logic [W-1:0] port_in,
  output logic         cap_valid,
  input  logic         cap_ready,
  output logic [W-1:0] cap_data,
  output logic         overflow
);
  localparam int STAGES = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic [W-1:0] samp;
  logic [W-1:0] mask;
  logic [W-1:0] word;
  logic         hit;
  logic         arm;

  chg_sync #(.W(W), .STAGES(STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(port_in), .q(samp)
  );

  chg_mask_reg #(.W(W), .RESET_VAL({W{1'b1}})) mask_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr(mask_wr),
    .wdata(mask_data), .mask(mask)
  );

  chg_detect #(.W(W)) det_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mask(mask), .samp(samp),
    .hit(hit), .arm(arm), .word(word)
  );

  chg_out_stage #(.W(W)) out_i (
    .clk(clk), .rst_n(rst_n), .hit(hit), .arm(arm), .word(word),
    .cap_ready(cap_ready), .cap_valid(cap_valid), .cap_data(cap_data),
    .overflow(overflow)
  );
endmodule

// File: rtl/chg_capture_chk.sv
module chg_capture_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         cap_valid,
  input logic         cap_ready,
  input logic [W-1:0] cap_data,
  input logic         overflow
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && !cap_ready |=> cap_valid && $stable(cap_data));

  assert_drop_only_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(cap_valid) && !$past(cap_ready));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && enable && $past(enable) |=> overflow);

  assert_no_load_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !cap_valid |=> !cap_valid);

  assert_arm_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_valid) |-> $past(enable) && $past(enable, 2));
endmodule

bind chg_capture chg_capture_chk #(.W(W)) chk_i (.*);

// File: tb/chg_capture_tb_top.sv
module chg_capture_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         mask_wr = 1'b0;
  logic [W-1:0] mask_data = '0;
  logic [W-1:0] port_in = '0;
  logic         cap_valid;
  logic         cap_ready = 1'b0;
  logic [W-1:0] cap_data;
  logic         overflow;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] cur = '0;

  logic         mon_en = 1'b0;
  int           got_n = 0;
  logic [W-1:0] got [64];

  always #5 clk = ~clk;

  chg_capture #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mask_wr(mask_wr),
    .mask_data(mask_data), .port_in(port_in), .cap_valid(cap_valid),
    .cap_ready(cap_ready), .cap_data(cap_data), .overflow(overflow)
  );

  always @(negedge clk) begin
    if (mon_en && cap_valid && cap_ready && got_n < 64) begin
      got[got_n] = cap_data;
      got_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [W-1:0] v);
    @(negedge clk);
    port_in = v;
    cur = v;
  endtask

  task automatic pop();
    cap_ready = 1'b1;
    @(negedge clk);
    cap_ready = 1'b0;
  endtask

  task automatic set_mask(input logic [W-1:0] m);
    @(negedge clk);
    enable = 1'b0;
    idle(1);
    mask_wr = 1'b1;
    mask_data = m;
    idle(1);
    mask_wr = 1'b0;
    enable = 1'b1;
    idle(3);
  endtask

  task automatic t_reset();
    check(cap_valid == 1'b0, "R1 valid after reset", W'(cap_valid), '0);
    check(overflow == 1'b0, "R1 overflow after reset", W'(overflow), '0);
  endtask

  task automatic t_arm();
    drive(32'hA5A5_5A5A);
    idle(4);
    enable = 1'b1;
    idle(6);
    check(cap_valid == 1'b0, "R4 no word on arming", W'(cap_valid), '0);
  endtask

  task automatic t_latency();
    logic [W-1:0] v;
    v = cur ^ 32'h8000_0000;  // bit 31 monitored by the reset mask (R1)
    drive(v);
    idle(2);
    check(cap_valid == 1'b0, "R2 not before third edge", W'(cap_valid), '0);
    idle(1);
    check(cap_valid == 1'b1, "R2 valid at third edge", W'(cap_valid), 1);
    check(cap_data == v, "R2 captured word", cap_data, v);
    pop();
    check(cap_valid == 1'b0, "R6 word removed by handshake", W'(cap_valid), '0);
  endtask

  task automatic t_mask_load();
    logic [W-1:0] v;
    set_mask(32'h0000_FFFF);
    drive(cur ^ 32'h0010_0000);
    idle(6);
    check(cap_valid == 1'b0, "R3 unmonitored change ignored", W'(cap_valid), '0);
    v = cur ^ 32'h0000_0008;
    drive(v);
    idle(4);
    check(cap_valid == 1'b1, "R10 new mask monitors bit 3", W'(cap_valid), 1);
    check(cap_data == v, "R2 full word incl. unmonitored bits", cap_data, v);
    pop();
  endtask

  task automatic t_mask_locked();
    logic [W-1:0] v;
    @(negedge clk);
    mask_wr = 1'b1;
    mask_data = 32'hFFFF_0000;
    idle(1);
    mask_wr = 1'b0;
    drive(cur ^ 32'h0040_0000);
    idle(6);
    check(cap_valid == 1'b0, "R9 write while enabled ignored", W'(cap_valid), '0);
    v = cur ^ 32'h0000_0020;
    drive(v);
    idle(4);
    check(cap_valid == 1'b1 && cap_data == v, "R9 old mask still active", cap_data, v);
    pop();
  endtask

  task automatic t_overflow();
    logic [W-1:0] v1;
    logic [W-1:0] v3;
    v1 = cur ^ 32'h1;
    drive(v1);
    idle(4);
    idle(3);
    check(cap_valid == 1'b1 && cap_data == v1, "R6 word held while not ready", cap_data, v1);
    drive(cur ^ 32'h2);
    idle(5);
    check(overflow == 1'b1, "R7 overflow set", W'(overflow), 1);
    check(cap_data == v1, "R7 held word kept", cap_data, v1);
    pop();
    check(cap_valid == 1'b0, "R7 dropped word not stored", W'(cap_valid), '0);
    v3 = cur ^ 32'h4;
    drive(v3);
    idle(4);
    check(cap_data == v3 && overflow == 1'b1, "R8 overflow sticky", W'(overflow), 1);
    pop();
    enable = 1'b0;
    idle(3);
    check(overflow == 1'b1, "R8 kept while disabled", W'(overflow), 1);
    enable = 1'b1;
    idle(2);
    check(overflow == 1'b0, "R8 cleared on arming", W'(overflow), '0);
  endtask

  task automatic t_back2back();
    logic [W-1:0] a;
    logic [W-1:0] b;
    got_n = 0;
    mon_en = 1'b1;
    cap_ready = 1'b1;
    a = cur ^ 32'h1;
    b = a ^ 32'h2;
    drive(a);
    drive(b);
    idle(6);
    check(got_n == 2, "R11 two words", W'(got_n), 2);
    check(got[0] == a && got[1] == b, "R11 order", got[1], b);
    check(overflow == 1'b0, "R11 no overflow", W'(overflow), '0);
    mon_en = 1'b0;
    cap_ready = 1'b0;
  endtask

  task automatic t_disabled();
    enable = 1'b0;
    drive(cur ^ 32'hF);
    idle(2);
    drive(cur ^ 32'h3);
    idle(6);
    check(cap_valid == 1'b0, "R5 no word while disabled", W'(cap_valid), '0);
    enable = 1'b1;
    idle(6);
    check(cap_valid == 1'b0, "R4 no word after re-arming", W'(cap_valid), '0);
  endtask

  task automatic t_random();
    logic [W-1:0] m;
    logic [W-1:0] exp_q [64];
    int           exp_n;
    m = 32'h00FF_0F0F;
    set_mask(m);
    exp_n = 0;
    got_n = 0;
    mon_en = 1'b1;
    cap_ready = 1'b1;
    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] tog;
      logic [W-1:0] nv;
      tog = $urandom & $urandom & $urandom;
      if (k % 3 == 0) tog = tog & ~m;
      nv = cur ^ tog;
      if (((nv ^ cur) & m) != '0) begin
        exp_q[exp_n] = nv;
        exp_n++;
      end
      drive(nv);
      idle(4);
    end
    idle(6);
    check(got_n == exp_n, "R2 R3 random capture count", W'(got_n), W'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++)
      check(got[i] == exp_q[i], "R2 random captured word", got[i], exp_q[i]);
    check(overflow == 1'b0, "R11 random no overflow", W'(overflow), '0);
    mon_en = 1'b0;
    cap_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    idle(3);
    t_arm();
    t_latency();
    t_mask_load();
    t_mask_locked();
    t_overflow();
    t_back2back();
    t_disabled();
    t_random();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule